// File: doc/BRIEF.md
# Transmit Reflectometry Distance Counter

This block times a transmission from the moment it starts until carrier disappears. The elapsed time is measured in ticks of a 10 MHz enable, one tick every 100 ns. It therefore gives the distance to a cable fault that reflects or kills the signal. A transmit-start pulse clears the count and opens a measurement. A carrier-loss pulse closes the measurement, and the result is then held until the next start.

Software reads the result through a 16-bit register view. The count sits in the low ten bits and the bits above it are zero. Data is returned only while the controller is stopped. Write strobes are accepted on the access port and have no effect. A hardware reset (asynchronous, active low) clears the count, and so does a software reset (synchronous, active high).

Top module: `tdr_span_counter`

## Requirements
- R1: `reg_rdata` carries the count in bits 9:0, and bits 15:10 are always zero.
- R2: While a measurement is open, each cycle with `tick_en` high adds one to the count. With `tick_en` low, the count does not change.
- R3: A cycle with `tx_start` high (and `carrier_lost` low) clears the count to 0 at the next edge and opens a measurement. A tick in that same cycle is not counted.
- R4: A cycle with `carrier_lost` high closes the measurement. A tick in that cycle is not counted. Afterwards the count holds, whatever the ticks do, until the next start or reset.
- R5: The count saturates at 1023. Further ticks leave it at 1023 and it never wraps to 0.
- R6: When `tx_start` and `carrier_lost` are high in the same cycle, the count becomes 0 and no measurement opens, so later ticks leave it at 0.
- R7: `reg_rdata` shows the count in the same cycle only when `reg_rd` is high, `reg_wr` is low and `stopped` is high. In every other case it reads 0.
- R8: A cycle with `reg_wr` high leaves the count exactly as it would have been without the write.
- R9: A low `hw_rst_n` clears the count at once, without waiting for a clock edge, and closes the measurement. A high `sw_rst` does the same at the next clock edge, and it takes priority over a start in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| hw_rst_n | input | 1 | Hardware reset, asynchronous, active low |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| tick_en | input | 1 | 10 MHz count enable, one cycle wide |
| tx_start | input | 1 | Transmission start pulse |
| carrier_lost | input | 1 | Carrier loss pulse |
| stopped | input | 1 | Controller stopped flag; gates reads |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe (ignored) |
| reg_rdata | output | 16 | Register view: zero-extended count |

## Verification
The bench builds the block with its default widths: a 10-bit counter inside a 16-bit register view. These widths put the saturation point of 1023 within reach of a run of about a thousand ticks, and the bench drives that run to check that the count stops at 1023 rather than wrapping. A table of per-cycle vectors covers the following, each as a read value predicted cycle by cycle:
- opening, ticking, closing and holding a measurement
- the void case of a start and a carrier loss in the same cycle
- masked reads
- writes
- software reset

Directed steps then cover the asynchronous hardware reset in the middle of a measurement, and the behaviour after it.

// File: rtl/tdr_span_pkg.sv
package tdr_span_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_RUN  = 1'b1
  } win_e;

  // Saturating step: stays at lim once reached.
  function automatic int unsigned sat_step(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 32'd1;
  endfunction

  // Largest value of an n-bit counter.
  function automatic int unsigned top_of(input int unsigned nbits);
    return (32'd1 << nbits) - 32'd1;
  endfunction

endpackage

// File: rtl/tdr_span_window.sv
module tdr_span_window
  import tdr_span_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic tx_start,
  input  logic carrier_lost,
  input  logic tick_en,
  output logic run,
  output logic clr_evt,
  output logic adv_evt
);

  win_e state_q, state_d;
  logic open_evt;
  logic close_evt;

  assign open_evt  = tx_start & ~carrier_lost & ~sw_rst;
  assign close_evt = carrier_lost | sw_rst;
  assign clr_evt   = tx_start | sw_rst;

  always_comb begin
    state_d = state_q;
    if (close_evt)     state_d = WIN_IDLE;
    else if (open_evt) state_d = WIN_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WIN_IDLE;
    else        state_q <= state_d;
  end

  assign run     = (state_q == WIN_RUN);
  assign adv_evt = run & tick_en & ~tx_start & ~close_evt;

endmodule

// File: rtl/tdr_span_count.sv
module tdr_span_count
  import tdr_span_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  output logic [CNT_W-1:0] count
);

  localparam int unsigned CNT_MAX = top_of(CNT_W);

  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clear)    count_d = '0;
    else if (adv) count_d = CNT_W'(sat_step(32'(count), CNT_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

endmodule

// File: rtl/tdr_span_regview.sv
module tdr_span_regview #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned REG_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic             rd,
  input  logic             wr,
  input  logic             stopped,
  output logic [REG_W-1:0] rdata
);

  localparam int unsigned PAD_W = REG_W - CNT_W;

  logic grant;

  assign grant = rd & ~wr & stopped;
  assign rdata = grant ? {{PAD_W{1'b0}}, count} : '0;

endmodule

// File: rtl/tdr_span_counter.sv
module tdr_span_counter #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             hw_rst_n,
  input  logic             sw_rst,
  input  logic             tick_en,
  input  logic             tx_start,
  input  logic             carrier_lost,
  input  logic             stopped,
  input  logic             reg_rd,
  input  logic             reg_wr,
  output logic [REG_W-1:0] reg_rdata
);

  logic             meas_active;
  logic             clr_evt;
  logic             adv_evt;
  logic [CNT_W-1:0] count_q;

  tdr_span_window u_win (
    .clk          (clk),
    .rst_n        (hw_rst_n),
    .sw_rst       (sw_rst),
    .tx_start     (tx_start),
    .carrier_lost (carrier_lost),
    .tick_en      (tick_en),
    .run          (meas_active),
    .clr_evt      (clr_evt),
    .adv_evt      (adv_evt)
  );

  tdr_span_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (hw_rst_n),
    .clear (clr_evt),
    .adv   (adv_evt),
    .count (count_q)
  );

  tdr_span_regview #(.CNT_W(CNT_W), .REG_W(REG_W)) u_view (
    .count   (count_q),
    .rd      (reg_rd),
    .wr      (reg_wr),
    .stopped (stopped),
    .rdata   (reg_rdata)
  );

endmodule

// File: rtl/tdr_span_chk.sv
module tdr_span_chk #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_rst,
  input logic             tick_en,
  input logic             tx_start,
  input logic             carrier_lost,
  input logic             stopped,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_rdata,
  input logic [CNT_W-1:0] count_q,
  input logic             meas_active
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:CNT_W] == '0);

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_active && tick_en && !tx_start && !carrier_lost && !sw_rst && count_q != CMAX)
    |=> (count_q == $past(count_q) + 1'b1));

  p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (count_q == '0));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!meas_active && !tx_start && !sw_rst) |=> $stable(count_q));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CMAX && !tx_start && !sw_rst) |=> (count_q == CMAX));

  p_void_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && carrier_lost) |=> !meas_active);

  p_read_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && stopped && !reg_wr) |-> (reg_rdata == '0));

  p_sw_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (count_q == '0 && !meas_active));

endmodule

bind tdr_span_counter tdr_span_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_n        (hw_rst_n),
  .sw_rst       (sw_rst),
  .tick_en      (tick_en),
  .tx_start     (tx_start),
  .carrier_lost (carrier_lost),
  .stopped      (stopped),
  .reg_rd       (reg_rd),
  .reg_wr       (reg_wr),
  .reg_rdata    (reg_rdata),
  .count_q      (count_q),
  .meas_active  (meas_active)
);

// File: tb/tb_tdr_span_counter.sv
`timescale 1ns/100ps
module tb_tdr_span_counter;

  logic        clk = 1'b0;
  logic        hw_rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        tick_en = 1'b0;
  logic        tx_start = 1'b0;
  logic        carrier_lost = 1'b0;
  logic        stopped = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_rdata;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tdr_span_counter dut (
    .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .tick_en(tick_en),
    .tx_start(tx_start), .carrier_lost(carrier_lost), .stopped(stopped),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
  );

  // {sw_rst, tx_start, carrier_lost, tick_en, stopped, reg_rd, reg_wr, expected read}
  localparam int NV = 17;
  localparam logic [22:0] VEC [NV] = '{
    {7'b0100110, 16'd0},  // R3 open; tick absent
    {7'b0001110, 16'd0},  // R2 tick
    {7'b0001110, 16'd1},  // R2 tick
    {7'b0000110, 16'd2},  // R2 no tick, count held
    {7'b0001111, 16'd0},  // R7 write masks read, R8 tick still counts
    {7'b0001010, 16'd0},  // R7 rd without stopped reads 0
    {7'b0011110, 16'd4},  // R4 loss; tick in this cycle not counted, R8 count intact
    {7'b0001110, 16'd4},  // R4 hold
    {7'b0001110, 16'd4},  // R4 hold
    {7'b0111110, 16'd4},  // R6 start+loss together
    {7'b0001110, 16'd0},  // R6 cleared, not counting
    {7'b0101110, 16'd0},  // R3 start with tick: tick ignored
    {7'b0001100, 16'd0},  // R7 stopped but no rd
    {7'b0001110, 16'd1},  // R2
    {7'b1001110, 16'd2},  // R9 sw reset
    {7'b0001110, 16'd0},  // R9 cleared, window closed
    {7'b0000110, 16'd0}   // R9 still 0
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive(input logic [6:0] c);
    {sw_rst, tx_start, carrier_lost, tick_en, stopped, reg_rd, reg_wr} = c;
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // reset state, R9 and R1
    drive(7'b0000110);
    #1;
    check("R9 reset value", reg_rdata, 16'd0);
    repeat (3) @(negedge clk);
    hw_rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][22:16]);
      #1;
      check($sformatf("vector %0d", i), reg_rdata, VEC[i][15:0]);
      @(negedge clk);
    end

    // R5 saturation
    drive(7'b0100110);
    @(negedge clk);
    drive(7'b0001110);
    for (int k = 0; k < 1030; k++) @(negedge clk);
    #1;
    check("R5 saturates at 1023", reg_rdata, 16'd1023);
    check("R1 upper bits zero", {10'd0, reg_rdata[15:10]}, 16'd0);
    @(negedge clk);
    drive(7'b0011110);
    @(negedge clk);
    drive(7'b0001110);
    #1;
    check("R4 hold at 1023 after loss", reg_rdata, 16'd1023);
    @(negedge clk);

    // R9 asynchronous hardware reset in the middle of a measurement
    drive(7'b0100110);
    @(negedge clk);
    drive(7'b0001110);
    repeat (3) @(negedge clk);
    #1;
    check("R2 three ticks", reg_rdata, 16'd3);
    #0.5;
    hw_rst_n = 1'b0;
    #0.5;
    check("R9 async clear", reg_rdata, 16'd0);
    @(negedge clk);
    hw_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R9 window closed after reset", reg_rdata, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule